// File: doc/BRIEF.md
# UART Receiver with Receive FIFO

This block receives 8N1 asynchronous serial frames on a single line and queues the bytes in a 16-entry receive FIFO. The line is oversampled 16 times per bit, using a fixed clock divisor. The host reaches the block through a small register port. A control register holds the receive enable and a trigger-level select. A status register gathers the flags for data-ready, threshold, break, framing error and overrun. A data register pops one byte on each read. A count register gives the number of bytes held and the synchronised line level.

The threshold flag follows the FIFO fill level against the chosen trigger. When that flag rises, a one-cycle interrupt pulse is sent to the host. A status flag can be cleared only by a write of 0 after a status read that returned that flag as 1. Because of this, a host cannot drop an event that it has not yet seen.

Register map (addr): 0 control, 1 status, 2 receive data, 3 count and line level.

Top module: `uart_rx_fifo`

## Requirements
- R1: An 8N1 frame, sent least significant bit first with a high stop bit, is stored in the FIFO. Reads of address 2 return the stored bytes in arrival order, one byte per read.
- R2: Address 3 bits [4:0] give the number of bytes held in the FIFO, from 0 to 16.
- R3: The threshold flag (status bit 1) is set while the count is at or above the trigger. Control bits [2:1] choose the trigger: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 bytes.
- R4: `irq_rx` pulses for exactly one cycle each time the threshold flag goes from 0 to 1.
- R5: A status flag clears only when 0 is written to its bit after a status read that returned it as 1. A write of 0 without that earlier read leaves the flag set. A write of 1 has no effect.
- R6: A frame with a low stop bit and non-zero data sets the framing-error flag (status bit 3). Its byte is still stored.
- R7: A frame that is all low, stop bit included, sets the break flag (status bit 2). It is not stored, and the count does not change.
- R8: The data-ready flag (status bit 0) sets when the FIFO holds at least one byte but fewer than the trigger, and no frame has started for 15 bit periods.
- R9: A frame that completes while the FIFO is full is discarded and sets the overrun flag (status bit 4). The count stays at 16.
- R10: A data read while the FIFO is empty returns the last byte read and leaves the count at 0.
- R11: While control bit 0 (receive enable) is 0, frames on the line are ignored. The reset value of the control register is 0.
- R12: Address 3 bit 7 shows the current line level after a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the FIFO at address 2) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq_rx | output | 1 | One-cycle pulse on the rising edge of the threshold flag |

## Verification
The assertions assume that the host never issues a read and a write in the same cycle. They also assume that the line holds each bit for a full bit period of 16 ticks. The bench drives every bit for exactly 64 clocks, which is the default divisor times 16. It performs register accesses one at a time, each on its own falling edge, and it releases the line to high before the next frame starts.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int CLK_DIV = 4,
  parameter int DEPTH   = 16,
  parameter int TO_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_rx
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int DVW = $clog2(CLK_DIV + 1);
  localparam int TO_TICKS = TO_BITS * 16;
  localparam int TOW = $clog2(TO_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_WAIT} st_t;

  function automatic logic [CW-1:0] trig_of(input logic [1:0] s);
    case (s)
      2'd0:    return CW'(1);
      2'd1:    return CW'(4);
      2'd2:    return CW'(8);
      default: return CW'(DEPTH - 2);
    endcase
  endfunction

  logic [1:0]     rsync;
  logic           rx_s;
  logic [DVW-1:0] div;
  logic           tick;
  st_t            state;
  logic [3:0]     sub;
  logic [2:0]     nbit;
  logic [7:0]     shreg;
  logic [2:0]     ctrl;
  logic [4:0]     flags, seen;
  logic [7:0]     mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt, trig;
  logic [7:0]     last;
  logic [TOW-1:0] tcnt;

  assign rx_s = rsync[1];
  assign tick = (div == DVW'(CLK_DIV - 1));
  assign trig = trig_of(ctrl[2:1]);

  wire frame_done = (state == S_STOP) && tick && (sub == 4'd15);
  wire good       = frame_done && rx_s;
  wire brk_evt    = frame_done && !rx_s && (shreg == 8'd0);
  wire fe_evt     = frame_done && !rx_s && (shreg != 8'd0);
  wire push_req   = good || fe_evt;
  wire pop_req    = rd_en && (addr == 2'd2);
  wire pop        = pop_req && (cnt != '0);
  wire full       = (cnt == CW'(DEPTH));
  wire push       = push_req && (!full || pop);
  wire ovr_evt    = push_req && !push;
  wire rdf_cond   = (cnt >= trig);
  wire dr_evt     = (tcnt == TOW'(TO_TICKS));
  wire st_wr      = wr_en && (addr == 2'd1);
  wire st_rd      = rd_en && (addr == 2'd1);

  wire [4:0] set_v = {ovr_evt, fe_evt, brk_evt, rdf_cond, dr_evt};
  wire [4:0] clr_v = st_wr ? (~wdata[4:0] & seen) : 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsync <= 2'b11;
      div   <= '0;
    end else begin
      rsync <= {rsync[0], rxd};
      div   <= tick ? '0 : div + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sub   <= '0;
      nbit  <= '0;
      shreg <= '0;
    end else if (!ctrl[0]) begin
      state <= S_IDLE;
    end else if (tick) begin
      case (state)
        S_IDLE: if (!rx_s) begin state <= S_START; sub <= '0; end
        S_START:
          if (sub == 4'd7) begin
            state <= rx_s ? S_IDLE : S_DATA;
            sub   <= '0;
            nbit  <= '0;
          end else sub <= sub + 1'b1;
        S_DATA:
          if (sub == 4'd15) begin
            shreg <= {rx_s, shreg[7:1]};
            sub   <= '0;
            if (nbit == 3'd7) state <= S_STOP;
            else nbit <= nbit + 1'b1;
          end else sub <= sub + 1'b1;
        S_STOP:
          if (sub == 4'd15) state <= rx_s ? S_IDLE : S_WAIT;
          else sub <= sub + 1'b1;
        default: if (rx_s) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= shreg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      last <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop) begin
        rp   <= rp + 1'b1;
        last <= mem[rp];
      end
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tcnt <= '0;
    else if (state != S_IDLE || cnt == '0 || rdf_cond) tcnt <= '0;
    else if (tick && !dr_evt) tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      flags  <= '0;
      seen   <= '0;
      irq_rx <= 1'b0;
    end else begin
      if (wr_en && addr == 2'd0) ctrl <= wdata[2:0];
      flags  <= (flags & ~clr_v) | set_v;
      irq_rx <= rdf_cond && !flags[1];
      if (st_rd) seen <= seen | flags;
      else if (st_wr) seen <= seen & wdata[4:0];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {5'd0, ctrl};
      2'd1:    rdata = {3'd0, flags};
      2'd2:    rdata = (cnt != '0) ? mem[rp] : last;
      default: rdata = {rx_s, 7'(cnt)};
    endcase
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  // R3
  thresh_set_chk: assert property (@(posedge clk) disable iff (!rst_n) rdf_cond |=> flags[1]);
  // R4
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_rx |-> flags[1] && !$past(flags[1]));
  // R7
  brk_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n) (brk_evt && !pop) |=> cnt == $past(cnt));
  // R9
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) (push_req && full && !pop) |=> flags[4] && cnt == CW'(DEPTH));
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n) (pop_req && cnt == '0 && !push_req) |=> cnt == '0);
  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !ctrl[0] |=> state == S_IDLE);
endmodule

// File: tb/sim_uart_rx_fifo.sv
module sim_uart_rx_fifo;
  localparam int BIT = 64;
  logic clk = 0, rst_n = 0, rxd = 1, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq_rx;
  int tests = 0, fails = 0, irq_cnt = 0, cyc = 0;
  logic [7:0] q[$];
  logic [7:0] v;

  always #4 clk = ~clk;

  uart_rx_fifo u0 (.clk(clk), .rst_n(rst_n), .rxd(rxd), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .irq_rx(irq_rx));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && irq_rx) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input int got, input int exp, input string tag);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    @(negedge clk); rxd = 0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT) @(negedge clk);
    rxd = 1;
    repeat (BIT / 2) @(negedge clk);
  endtask

  task automatic sendq(input logic [7:0] b);
    send(b, 1'b1);
    q.push_back(b);
  endtask

  task automatic clear_all();
    rd(2'd1, v);
    wr(2'd1, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, v); chk(v, 8'h00, "R11 ctrl reset");
    rd(2'd1, v); chk(v, 8'h00, "R5 status reset");
    rd(2'd3, v); chk(v, 8'h80, "R2 count reset with line high");

    rxd = 0; repeat (4) @(negedge clk);
    rd(2'd3, v); chk(v[7], 0, "R12 line low");
    rxd = 1; repeat (4) @(negedge clk);
    rd(2'd3, v); chk(v[7], 1, "R12 line high");

    send(8'h55, 1'b1);
    rd(2'd3, v); chk(v[4:0], 0, "R11 disabled ignores frame");

    wr(2'd0, 8'h03);
    sendq(8'h31); sendq(8'hC2); sendq(8'h07);
    rd(2'd3, v); chk(v[4:0], 3, "R2 count three");
    rd(2'd1, v); chk(v[1], 0, "R3 below trigger 4");
    chk(irq_cnt, 0, "R4 no pulse yet");
    sendq(8'hE8);
    rd(2'd1, v); chk(v[1], 1, "R3 at trigger 4");
    chk(irq_cnt, 1, "R4 single pulse");
    for (int i = 0; i < 4; i++) begin
      rd(2'd2, v); chk(v, q.pop_front(), "R1 data order");
    end
    rd(2'd3, v); chk(v[4:0], 0, "R2 drained");
    rd(2'd1, v); chk(v[1], 1, "R5 flag held after drain");
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk(v[1], 0, "R5 cleared after read-then-write0");

    sendq(8'h9A);
    rd(2'd1, v); chk(v[0], 0, "R8 not yet idle long");
    repeat (15 * BIT + 100) @(negedge clk);
    rd(2'd1, v); chk(v[0], 1, "R8 data-ready after timeout");
    rd(2'd2, v); chk(v, q.pop_front(), "R1 data after timeout");
    clear_all();
    rd(2'd1, v); chk(v, 8'h00, "R8 flags clear");

    send(8'hA5, 1'b0);
    rd(2'd3, v); chk(v[4:0], 1, "R6 framed byte stored");
    wr(2'd1, 8'hFF);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk(v[3], 1, "R5 write0 without read keeps flag");
    chk(v[3], 1, "R6 framing error flag");
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk(v[3], 0, "R5 cleared after read");
    rd(2'd2, v); chk(v, 8'hA5, "R6 framed byte value");

    send(8'h00, 1'b0);
    rd(2'd3, v); chk(v[4:0], 0, "R7 break not stored");
    rd(2'd1, v); chk(v[2], 1, "R7 break flag");
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk(v, 8'h00, "R7 break cleared");

    wr(2'd0, 8'h07);
    for (int i = 0; i < 16; i++) sendq(8'(8'h40 + i * 3));
    rd(2'd3, v); chk(v[4:0], 16, "R2 full");
    chk(irq_cnt, 2, "R4 pulse at trigger 14");
    send(8'h77, 1'b1);
    rd(2'd3, v); chk(v[4:0], 16, "R9 count held at full");
    rd(2'd1, v); chk(v[4], 1, "R9 overrun flag");
    for (int i = 0; i < 16; i++) begin
      rd(2'd2, v); chk(v, q.pop_front(), "R1 data after overrun");
    end
    rd(2'd2, v); chk(v, 8'h40 + 15 * 3, "R10 empty read returns last");
    rd(2'd3, v); chk(v[4:0], 0, "R10 count stays zero");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule